// File: doc/BRIEF.md
# Modulus Counter With Carry-Out

This block is one stage of a cascaded time counter. It holds a single digit that starts at zero and moves up by one on each rising clock edge on which its increment enable is high. The modulus is set by a parameter. Once the count has reached modulus minus one, the next enabled edge returns it to zero. A second parameter sets the width of the count register, so the same block can also serve as a wide prescaler.

The carry-out tells the next stage to advance. It is a combinational signal. It is high only in a cycle where the enable is high and the count is at its top value, so it lines up with the edge on which this stage wraps. A count that rests at its top value with the enable low does not raise the carry.

Reset is synchronous and active high. It takes priority over the enable and holds the carry low.

Top module: `wrap_counter`

## Requirements
- R1: With `rst` high at a rising edge, the count is 0 after that edge, whatever `incEn` is. Reset takes priority over increment.
- R2: While `rst` is high, `carryOut` is low, even when `incEn` is high and the count is at its top value.
- R3: With `rst` low, `incEn` high and the count below MOD_VAL-1, the count rises by exactly one at the next rising edge.
- R4: With `rst` low and `incEn` low, the count holds its value across the edge.
- R5: With `rst` low, `incEn` high and the count equal to MOD_VAL-1, the count is 0 after the next rising edge.
- R6: `carryOut` is high in a cycle exactly when `rst` is low, `incEn` is high and the count equals MOD_VAL-1. It is set combinationally in that same cycle, before the wrapping edge.
- R7: With the count at MOD_VAL-1 and `incEn` low, `carryOut` is low.
- R8: The count never exceeds MOD_VAL-1.
- R9: The defaults are MOD_VAL = 10 and CNT_W = 4. CNT_W must be wide enough to hold MOD_VAL-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| incEn | input | 1 | Advance the count at the next edge when high |
| carryOut | output | 1 | Combinational carry to the next stage |
| countVal | output | CNT_W | Current digit value |

## Verification
The bench runs a modulus-10 instance and a modulus-6 instance side by side through at least two full wraps each.

- **Stalling enable.** The enable is stalled in an irregular pattern so that the count rests at its top value with the enable low. A design that drives the carry from the top value alone would raise a spurious carry there.
- **Registered carry.** The carry is sampled in the same cycle as the enable. A registered carry would show up one cycle late, on the cycle after the wrap.
- **Reset against increment.** Reset is applied mid-count with the enable high and the count at its top. A design that lets increment win, or lets the carry through during reset, would then show a nonzero count or a carry pulse.
- **Modulus 6.** The modulus-6 instance catches a wrap value hard-coded to 9.

// File: rtl/wrap_counter_pkg.sv
package wrap_counter_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;    // synchronous reset request
    logic advance;  // step the count by one
    logic wrap;     // return the count to zero from its top value
  } ctrlStrobes_t;

endpackage

// File: rtl/wrap_counter_ctrl.sv
module wrap_counter_ctrl
  import wrap_counter_pkg::*;
(
  input  logic         rst,
  input  logic         incEn,
  input  logic         atTop,
  output ctrlStrobes_t strobes,
  output logic         carryOut
);

  logic stepReq;

  always_comb begin
    stepReq         = incEn && !rst;
    strobes.clear   = rst;
    strobes.advance = stepReq && !atTop;
    strobes.wrap    = stepReq && atTop;
    // Carry is combinational: it is high in the very cycle the wrap is requested.
    carryOut        = strobes.wrap;
  end

endmodule

// File: rtl/wrap_counter_dp.sv
module wrap_counter_dp
  import wrap_counter_pkg::*;
#(
  parameter int MOD_VAL = 10,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] countVal,
  output logic             atTop
);

  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MOD_VAL - 1);

  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (strobes.clear || strobes.wrap) begin
      countQ <= '0;
    end else if (strobes.advance) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  assign atTop    = (countQ == TOP_VAL);
  assign countVal = countQ;

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter
  import wrap_counter_pkg::*;
#(
  parameter int MOD_VAL = 10,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incEn,
  output logic             carryOut,
  output logic [CNT_W-1:0] countVal
);

  ctrlStrobes_t strobes;
  logic         atTop;

  wrap_counter_ctrl ctrl_i (
    .rst      (rst),
    .incEn    (incEn),
    .atTop    (atTop),
    .strobes  (strobes),
    .carryOut (carryOut)
  );

  wrap_counter_dp #(
    .MOD_VAL (MOD_VAL),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk      (clk),
    .strobes  (strobes),
    .countVal (countVal),
    .atTop    (atTop)
  );

endmodule

// File: rtl/wrap_counter_chk.sv
module wrap_counter_chk #(
  parameter int MOD_VAL = 10,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             incEn,
  input logic             carryOut,
  input logic [CNT_W-1:0] countVal
);

  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(MOD_VAL - 1);

  logic pastValid = 1'b0;

  always_ff @(posedge clk) pastValid <= 1'b1;

  p_sync_clear_r1: assert property (@(posedge clk) disable iff (!pastValid)
    rst |=> (countVal == '0));

  p_no_carry_in_reset_r2: assert property (@(posedge clk) disable iff (!pastValid)
    rst |-> !carryOut);

  p_step_up_r3: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (incEn && countVal != TOP_VAL) |=> (countVal == $past(countVal) + CNT_W'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst || !pastValid)
    !incEn |=> $stable(countVal));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (incEn && countVal == TOP_VAL) |=> (countVal == '0));

  p_carry_when_due_r6: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (incEn && countVal == TOP_VAL) |-> carryOut);

  p_carry_needs_enable_r7: assert property (@(posedge clk) disable iff (rst || !pastValid)
    carryOut |-> (incEn && countVal == TOP_VAL));

  p_in_range_r8: assert property (@(posedge clk) disable iff (rst || !pastValid)
    countVal <= TOP_VAL);

endmodule

bind wrap_counter wrap_counter_chk #(
  .MOD_VAL (MOD_VAL),
  .CNT_W   (CNT_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .incEn    (incEn),
  .carryOut (carryOut),
  .countVal (countVal)
);

// File: tb/wrap_counter_tb_top.sv
module wrap_counter_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    exp10;
    int    exp6;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       incEn = 1'b0;
  logic       carry10;
  logic       carry6;
  logic [3:0] count10;
  logic [2:0] count6;

  int         checks = 0;
  int         fails  = 0;
  int         m10 = 0;
  int         m6  = 0;
  bit         done = 1'b0;
  expItem_t   scoreQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // R9: default parameters give modulus 10, width 4
  wrap_counter dut_i (
    .clk(clk), .rst(rst), .incEn(incEn), .carryOut(carry10), .countVal(count10)
  );

  wrap_counter #(.MOD_VAL(6), .CNT_W(3)) dut6_i (
    .clk(clk), .rst(rst), .incEn(incEn), .carryOut(carry6), .countVal(count6)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string carryTag(input bit r, input bit inc, input bit top);
    if (r) return "R2";
    if (!inc && top) return "R7";
    return "R6";
  endfunction

  function automatic string stepTag(input bit r, input bit inc, input bit top);
    if (r) return "R1";
    if (!inc) return "R4";
    if (top) return "R5 R9";
    return "R3";
  endfunction

  // Driver: set inputs away from the edge, check the same-cycle carry,
  // then push the expected counts for after the coming edge.
  task automatic drive(input bit r, input bit inc);
    expItem_t it;
    bit top10;
    bit top6;
    @(negedge clk);
    rst   = r;
    incEn = inc;
    #1;
    if (!r) begin
      top10 = (m10 == 9);
      top6  = (m6 == 5);
      check({carryTag(r, inc, top10), " carry mod10"}, int'(carry10), int'(inc && top10));
      check({carryTag(r, inc, top6), " carry mod6"}, int'(carry6), int'(inc && top6));
    end else begin
      check("R2 carry mod10 in reset", int'(carry10), 0);
      check("R2 carry mod6 in reset", int'(carry6), 0);
    end
    it.tag = stepTag(r, inc, !r && (m10 == 9 || m6 == 5));
    if (r) begin
      m10 = 0;
      m6  = 0;
    end else if (inc) begin
      m10 = (m10 == 9) ? 0 : m10 + 1;
      m6  = (m6 == 5) ? 0 : m6 + 1;
    end
    it.exp10 = m10;
    it.exp6  = m6;
    scoreQ.push_back(it);
  endtask

  // Monitor: compare the counts shortly after each edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        check({it.tag, " count mod10"}, int'(count10), it.exp10);
        check({it.tag, " count mod6"}, int'(count6), it.exp6);
        check("R8 range mod10", int'(count10 <= 4'd9), 1);
        check("R8 range mod6", int'(count6 <= 3'd5), 1);
      end
    end
  end

  initial begin
    // R1 R2: reset with the enable high
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    // R3 R5 R6: continuous run over more than two wraps of each instance
    for (int i = 0; i < 25; i++) drive(1'b0, 1'b1);
    // R4 R7: irregular stalls, so the count rests at its top value
    for (int i = 0; i < 40; i++) drive(1'b0, (i % 3) != 0);
    // advance to the top of mod 10, stall there, then wrap
    while (m10 != 9) drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    // R1 R2: reset at the top value with the enable high
    while (m10 != 9) drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    for (int i = 0; i < 12; i++) drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule